// File: doc/BRIEF.md
# Peripheral Card Address Decoder for ROM and Floppy Controller

This block decodes the address bus of a byte-wide peripheral card on a 16-bit-address bus. While the card's enable bit from its control port is set and a memory cycle is active, an 8 KB window starting at 0x4000 is claimed. Inside that window the card ROM is split into two chip enables. The top 16 bytes of the window belong to a floppy disk controller rather than to the ROM. As a result, those ROM bytes cannot be reached.

The controller has separate addresses for reading and for writing its registers. The lower eight bytes of the 16-byte block are the read half: status, track, sector and data, in that order at 0x5FF0, 0x5FF2, 0x5FF4 and 0x5FF6. The upper eight bytes are the write half: command, track, sector and data at 0x5FF8, 0x5FFA, 0x5FFC and 0x5FFE. Only even addresses can strobe a register. The block also drives a 2-bit register index for the controller, and one enable shared by the card's data transceiver and the bus read-enable line.

All outputs are combinational and active high.

Top module: `dskdec_top`

## Requirements
- R1: While `card_on_i` is 0, every output is 0 for any address and direction.
- R2: While `mem_en_i` is 0, every output is 0 for any address and direction.
- R3: For an enabled access in 0x4000 to 0x5FEF, exactly one ROM enable is 1: `rom_ce_o[0]` for 0x4000 to 0x4FFF and `rom_ce_o[1]` for 0x5000 to 0x5FEF. In this range the controller select is 0.
- R4: For an enabled access in 0x5FF0 to 0x5FFF, `fdc_cs_o` is 1 and both ROM enables are 0.
- R5: `fdc_reg_o` equals address bits [2:1] while `fdc_cs_o` is 1, and is 0 otherwise.
- R6: `fdc_rd_o` is 1 only for a read (`wr_i`=0) at an even address with bit 3 clear (0x5FF0 to 0x5FF6).
- R7: `fdc_wr_o` is 1 only for a write (`wr_i`=1) at an even address with bit 3 set (0x5FF8 to 0x5FFE).
- R8: A write into the read half, or a read from the write half, has these effects:
  - it raises neither strobe;
  - it leaves `xcvr_en_o` and `bus_rd_en_o` at 0;
  - it still asserts `fdc_cs_o`.
- R9: At odd addresses in the controller range, neither strobe is raised.
- R10: `xcvr_en_o` and `bus_rd_en_o` are equal to each other. They are 1 exactly when a ROM enable is 1, or when the controller is selected with the direction matching the half addressed (odd addresses included).
- R11: Enabled accesses below 0x4000 or above 0x5FFF leave every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus byte address |
| mem_en_i | input | 1 | Memory cycle in progress, active high |
| wr_i | input | 1 | Bus write cycle, active high (0 = read) |
| card_on_i | input | 1 | Card enable bit from the control port |
| rom_ce_o | output | 2 | ROM chip enables, lower and upper 4 KB halves |
| fdc_cs_o | output | 1 | Controller chip select |
| fdc_rd_o | output | 1 | Controller register read strobe |
| fdc_wr_o | output | 1 | Controller register write strobe |
| fdc_reg_o | output | 2 | Controller register index |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_rd_en_o | output | 1 | Bus read-enable line |

## Verification
The checker tests on every evaluation the properties that hold for any input:
- no output is active without the card enable and a memory cycle;
- the ROM enables are mutually exclusive and never share a cycle with the controller select;
- no strobe fires on an odd address or against the half's direction;
- the register index tracks the address bits.

The exact address boundaries (0x4FFF versus 0x5000, and 0x5FEF versus 0x5FF0) can only be shown by the bench's scenarios. The same holds for the edges of the window and for the pairing of each register name with its read or write address.

// File: rtl/dskdec_pkg.sv
package dskdec_pkg;

  // Direction of a bus cycle as seen by the decoder.
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } bus_dir_e;

  // Strobe pair sent to the controller.
  typedef struct packed {
    logic rd;
    logic wr;
  } fdc_strobe_t;

endpackage

// File: rtl/dskdec_window.sv
module dskdec_window #(
  parameter int          ADDR_W   = 16,
  parameter int          WIN_BITS = 13,
  parameter logic [15:0] WIN_BASE = 16'h4000,
  parameter int          REG_BITS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_en_i,
  input  logic              card_on_i,
  output logic              rom_hit_o,
  output logic              reg_hit_o
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam int SUB_W = WIN_BITS - REG_BITS;

  logic win_hit;
  logic top_block;

  always_comb begin
    win_hit   = mem_en_i && card_on_i &&
                (addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
    top_block = &addr_i[WIN_BITS-1:REG_BITS];
    reg_hit_o = win_hit && top_block;
    rom_hit_o = win_hit && !top_block;
  end

  // Guard against parameter sets that leave no ROM space.
  if (TAG_W < 1 || SUB_W < 1) begin : g_bad_params
    initial $fatal(1, "dskdec_window: window parameters out of range");
  end

endmodule

// File: rtl/dskdec_rom_banks.sv
module dskdec_rom_banks #(
  parameter int WIN_BITS = 13,
  parameter int BANKS    = 2
) (
  input  logic [WIN_BITS-1:0] offs_i,
  input  logic                rom_hit_i,
  output logic [BANKS-1:0]    ce_o
);
  localparam int SEL_W = $clog2(BANKS);

  logic [SEL_W-1:0] bank_sel;

  assign bank_sel = offs_i[WIN_BITS-1 -: SEL_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign ce_o[b] = rom_hit_i && (bank_sel == SEL_W'(b));
  end

endmodule

// File: rtl/dskdec_regmap.sv
module dskdec_regmap
  import dskdec_pkg::*;
#(
  parameter int REG_BITS = 4
) (
  input  logic [REG_BITS-1:0] offs_i,
  input  logic                reg_hit_i,
  input  logic                wr_i,
  output fdc_strobe_t         stb_o,
  output logic [REG_BITS-3:0] idx_o,
  output logic                dir_ok_o
);
  localparam int HALF_BIT = REG_BITS - 1;

  bus_dir_e half_dir;
  bus_dir_e cyc_dir;
  logic     even;

  always_comb begin
    half_dir = offs_i[HALF_BIT] ? DIR_WRITE : DIR_READ;
    cyc_dir  = wr_i ? DIR_WRITE : DIR_READ;
    even     = !offs_i[0];
    dir_ok_o = reg_hit_i && (half_dir == cyc_dir);
    stb_o.rd = dir_ok_o && even && (cyc_dir == DIR_READ);
    stb_o.wr = dir_ok_o && even && (cyc_dir == DIR_WRITE);
    idx_o    = reg_hit_i ? offs_i[HALF_BIT-1:1] : '0;
  end

endmodule

// File: rtl/dskdec_top.sv
module dskdec_top
  import dskdec_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          WIN_BITS = 13,
  parameter logic [15:0] WIN_BASE = 16'h4000,
  parameter int          REG_BITS = 4,
  parameter int          BANKS    = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                mem_en_i,
  input  logic                wr_i,
  input  logic                card_on_i,
  output logic [BANKS-1:0]    rom_ce_o,
  output logic                fdc_cs_o,
  output logic                fdc_rd_o,
  output logic                fdc_wr_o,
  output logic [REG_BITS-3:0] fdc_reg_o,
  output logic                xcvr_en_o,
  output logic                bus_rd_en_o
);
  logic        rom_hit;
  logic        reg_hit;
  logic        dir_ok;
  fdc_strobe_t stb;

  dskdec_window #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS),
    .WIN_BASE(WIN_BASE),
    .REG_BITS(REG_BITS)
  ) u_window (
    .addr_i   (addr_i),
    .mem_en_i (mem_en_i),
    .card_on_i(card_on_i),
    .rom_hit_o(rom_hit),
    .reg_hit_o(reg_hit)
  );

  dskdec_rom_banks #(
    .WIN_BITS(WIN_BITS),
    .BANKS   (BANKS)
  ) u_banks (
    .offs_i   (addr_i[WIN_BITS-1:0]),
    .rom_hit_i(rom_hit),
    .ce_o     (rom_ce_o)
  );

  dskdec_regmap #(
    .REG_BITS(REG_BITS)
  ) u_regmap (
    .offs_i   (addr_i[REG_BITS-1:0]),
    .reg_hit_i(reg_hit),
    .wr_i     (wr_i),
    .stb_o    (stb),
    .idx_o    (fdc_reg_o),
    .dir_ok_o (dir_ok)
  );

  always_comb begin
    fdc_cs_o    = reg_hit;
    fdc_rd_o    = stb.rd;
    fdc_wr_o    = stb.wr;
    xcvr_en_o   = rom_hit || dir_ok;
    bus_rd_en_o = xcvr_en_o;
  end

endmodule

// File: rtl/dskdec_checker.sv
module dskdec_checker (
  input logic [15:0] addr_i,
  input logic        mem_en_i,
  input logic        wr_i,
  input logic        card_on_i,
  input logic [1:0]  rom_ce_o,
  input logic        fdc_cs_o,
  input logic        fdc_rd_o,
  input logic        fdc_wr_o,
  input logic [1:0]  fdc_reg_o,
  input logic        xcvr_en_o,
  input logic        bus_rd_en_o
);
  logic any_out;
  logic in_win;

  always_comb begin
    any_out = (|rom_ce_o) || fdc_cs_o || fdc_rd_o || fdc_wr_o ||
              (|fdc_reg_o) || xcvr_en_o || bus_rd_en_o;
    in_win  = (addr_i >= 16'h4000) && (addr_i <= 16'h5FFF);

    a_r1_card_off_idle: assert (card_on_i || !any_out)
      else $error("R1: output active with card disabled");
    a_r2_no_cycle_idle: assert (mem_en_i || !any_out)
      else $error("R2: output active outside a memory cycle");
    a_r3_one_rom_bank: assert ($onehot0(rom_ce_o) && !(fdc_cs_o && (|rom_ce_o)))
      else $error("R3: ROM enables overlap");
    a_r4_regs_not_rom: assert (!((addr_i >= 16'h5FF0) && (|rom_ce_o)))
      else $error("R4: ROM enabled in register block");
    a_r5_index_tracks: assert (!fdc_cs_o || (fdc_reg_o == addr_i[2:1]))
      else $error("R5: register index mismatch");
    a_r6_rd_in_read_half: assert (!fdc_rd_o || (!wr_i && !addr_i[3] && fdc_cs_o))
      else $error("R6: read strobe outside read half");
    a_r7_wr_in_write_half: assert (!fdc_wr_o || (wr_i && addr_i[3] && fdc_cs_o))
      else $error("R7: write strobe outside write half");
    a_r8_wrong_dir_quiet: assert (!(fdc_cs_o && (wr_i != addr_i[3])) ||
                                  (!fdc_rd_o && !fdc_wr_o && !xcvr_en_o))
      else $error("R8: wrong-direction access not blocked");
    a_r9_odd_no_strobe: assert (!addr_i[0] || (!fdc_rd_o && !fdc_wr_o))
      else $error("R9: strobe on odd address");
    a_r10_enables_match: assert (xcvr_en_o == bus_rd_en_o)
      else $error("R10: transceiver and bus enable differ");
    a_r11_outside_quiet: assert (in_win || !any_out)
      else $error("R11: output active outside window");
  end

endmodule

bind dskdec_top dskdec_checker u_chk (
  .addr_i     (addr_i),
  .mem_en_i   (mem_en_i),
  .wr_i       (wr_i),
  .card_on_i  (card_on_i),
  .rom_ce_o   (rom_ce_o),
  .fdc_cs_o   (fdc_cs_o),
  .fdc_rd_o   (fdc_rd_o),
  .fdc_wr_o   (fdc_wr_o),
  .fdc_reg_o  (fdc_reg_o),
  .xcvr_en_o  (xcvr_en_o),
  .bus_rd_en_o(bus_rd_en_o)
);

// File: tb/dskdec_top_tb.sv
module dskdec_top_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        mem_en;
  logic        wr;
  logic        card_on;
  logic [1:0]  rom_ce;
  logic        fdc_cs, fdc_rd, fdc_wr, xcvr_en, bus_rd_en;
  logic [1:0]  fdc_reg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dskdec_top u_dut (
    .addr_i(addr), .mem_en_i(mem_en), .wr_i(wr), .card_on_i(card_on),
    .rom_ce_o(rom_ce), .fdc_cs_o(fdc_cs), .fdc_rd_o(fdc_rd), .fdc_wr_o(fdc_wr),
    .fdc_reg_o(fdc_reg), .xcvr_en_o(xcvr_en), .bus_rd_en_o(bus_rd_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s addr=%h wr=%0b: actual=%0d expected=%0d", req, what, addr, wr, act, exp);
    end
  endtask

  // Apply one access and compare all outputs with the requirement model.
  task automatic access(input logic [15:0] a, input logic w, input logic m,
                        input logic c, input string req);
    logic inw, regs, rom, dirok;
    logic [1:0] ce_e, idx_e;
    @(negedge clk);
    addr = a; wr = w; mem_en = m; card_on = c;
    #1;
    inw   = c && m && (a >= 16'h4000) && (a <= 16'h5FFF);
    regs  = inw && (a >= 16'h5FF0);
    rom   = inw && !regs;
    ce_e  = rom ? ((a < 16'h5000) ? 2'b01 : 2'b10) : 2'b00;
    dirok = regs && (a[3] == w);
    idx_e = regs ? a[2:1] : 2'b00;
    chk(req, "rom_ce",    int'(rom_ce),    int'(ce_e));
    chk(req, "fdc_cs",    int'(fdc_cs),    int'(regs));
    chk(req, "fdc_reg",   int'(fdc_reg),   int'(idx_e));
    chk(req, "fdc_rd",    int'(fdc_rd),    int'(dirok && !w && !a[0]));
    chk(req, "fdc_wr",    int'(fdc_wr),    int'(dirok && w && !a[0]));
    chk(req, "xcvr_en",   int'(xcvr_en),   int'(rom || dirok));
    chk(req, "bus_rd_en", int'(bus_rd_en), int'(rom || dirok));
  endtask

  task automatic t_r1_card_off();
    access(16'h4000, 1'b0, 1'b1, 1'b0, "R1");
    access(16'h5FF0, 1'b0, 1'b1, 1'b0, "R1");
    access(16'h5FF8, 1'b1, 1'b1, 1'b0, "R1");
  endtask

  task automatic t_r2_no_cycle();
    access(16'h4800, 1'b0, 1'b0, 1'b1, "R2");
    access(16'h5FF6, 1'b0, 1'b0, 1'b1, "R2");
    access(16'h5FFE, 1'b1, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_r3_rom_halves();
    access(16'h4000, 1'b0, 1'b1, 1'b1, "R3");
    access(16'h4FFF, 1'b0, 1'b1, 1'b1, "R3");
    access(16'h5000, 1'b0, 1'b1, 1'b1, "R3");
    access(16'h5FEF, 1'b0, 1'b1, 1'b1, "R3");
    access(16'h4A55, 1'b1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_r4_r5_r6_r7_regs();
    for (int i = 0; i < 16; i++) begin
      access(16'h5FF0 + 16'(i), 1'b0, 1'b1, 1'b1, "R4");
      access(16'h5FF0 + 16'(i), 1'b1, 1'b1, 1'b1, "R5");
    end
    // named registers: status/track/sector/data read, command/track/sector/data write
    access(16'h5FF0, 1'b0, 1'b1, 1'b1, "R6");
    access(16'h5FF6, 1'b0, 1'b1, 1'b1, "R6");
    access(16'h5FF8, 1'b1, 1'b1, 1'b1, "R7");
    access(16'h5FFE, 1'b1, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_r8_wrong_dir();
    access(16'h5FF2, 1'b1, 1'b1, 1'b1, "R8");
    access(16'h5FFC, 1'b0, 1'b1, 1'b1, "R8");
  endtask

  task automatic t_r9_odd();
    access(16'h5FF1, 1'b0, 1'b1, 1'b1, "R9");
    access(16'h5FFF, 1'b1, 1'b1, 1'b1, "R9");
  endtask

  task automatic t_r10_enables();
    access(16'h5123, 1'b0, 1'b1, 1'b1, "R10");
    access(16'h5FF4, 1'b0, 1'b1, 1'b1, "R10");
    access(16'h5FFB, 1'b1, 1'b1, 1'b1, "R10");
  endtask

  task automatic t_r11_outside();
    access(16'h3FFF, 1'b0, 1'b1, 1'b1, "R11");
    access(16'h6000, 1'b1, 1'b1, 1'b1, "R11");
    access(16'hFFF0, 1'b0, 1'b1, 1'b1, "R11");
    access(16'h1FF8, 1'b1, 1'b1, 1'b1, "R11");
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; mem_en = 1'b0; card_on = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle bus, all outputs low
    access(16'h0000, 1'b0, 1'b0, 1'b0, "R2");
    t_r1_card_off();
    t_r2_no_cycle();
    t_r3_rom_halves();
    t_r4_r5_r6_r7_regs();
    t_r8_wrong_dir();
    t_r9_odd();
    t_r10_enables();
    t_r11_outside();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule